// File: doc/BRIEF.md
# Serial EEPROM Page Staging Buffer and Write-Cycle Sequencer

This block sits between the bus protocol engine of a serial EEPROM and its memory array. While a write transaction is in progress the protocol engine hands it a one-shot event for each step: the start of the transaction, the received word address and every received data byte. The block holds those bytes in a one-page latch buffer, and a per-byte loaded mask records which buffer slots hold new data. Nothing reaches the array while bytes are still arriving.

When the protocol engine reports a stop, the block checks that at least one byte was loaded and that write protection is off. If both hold, it raises `busy` for a fixed number of clocks. In the first clocks of that interval it writes the loaded bytes into the array through a simple synchronous write port, one byte per clock. The protocol engine uses `busy` to withhold acknowledges, which lets a bus master poll for the end of the cycle. The page offset wraps inside the page, so a transaction longer than a page overwrites its own earlier bytes and never spills into the next page.

Top module: `eeprom_page_stager`

## Requirements
- R1: After reset, `busy` and `memWe` are both low.
- R2: An address event splits `addrIn` into a page number (bits ADDR_W-1..4) and an offset (bits 3..0). Each data byte is stored at the current offset, and the offset then advances by one. The page number is never changed by data bytes, and the array location written for a byte is {page, offset}.
- R3: After offset 15 the offset returns to 0. A later byte at an offset already loaded replaces the earlier byte, and no byte is written outside the addressed page.
- R4: The array is not written before a stop. A stop with at least one loaded byte and `wpIn` low sets `busy` high on the next clock.
- R5: Once set, `busy` stays high for exactly WRITE_CYCLES consecutive clocks.
- R6: During the first 16 busy clocks, offsets are scanned in ascending order. `memWe` is pulsed only for loaded offsets, and unloaded locations in the page keep their previous array contents.
- R7: A stop while `wpIn` is high starts no write cycle, leaves the array unchanged and discards the loaded bytes.
- R8: A stop with no data byte loaded since the transaction began leaves `busy` low and writes nothing.
- R9: A repeated-start event discards the loaded bytes, so a later stop without new data writes nothing.
- R10: Every input event that arrives while `busy` is high has no effect. This includes the final busy clock. The page used by the commit does not change during the cycle.
- R11: The loaded mask is cleared when a transaction begins and when a write cycle ends, so a commit writes only the bytes of its own transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrBegin | input | 1 | Pulse: a write transaction has been addressed |
| addrLoad | input | 1 | Pulse: `addrIn` holds the received word address |
| addrIn | input | ADDR_W | Full byte address (page number and offset) |
| dataValid | input | 1 | Pulse: `dataIn` holds a received data byte |
| dataIn | input | DATA_W | Received data byte |
| stopSeen | input | 1 | Pulse: stop condition ended the transaction |
| restartSeen | input | 1 | Pulse: repeated start replaced the stop |
| wpIn | input | 1 | Write-protect level, sampled at stop |
| busy | output | 1 | Write cycle in progress |
| memWe | output | 1 | Array write enable, one byte per clock |
| memAddr | output | ADDR_W | Array write address |
| memData | output | DATA_W | Array write data |

## Verification
Two functions can meet in one clock: the write-cycle sequencer retiring its final busy clock (and clearing the mask), and the protocol engine delivering a new data byte or address. The bench drives a data byte into exactly the last busy clock, and an address plus a data byte into the middle of the scan. It then judges the result from the ports. A following stop must not start a cycle, the array must hold only the committed byte, and the page in `memAddr` must stay fixed across the whole busy interval.

// File: rtl/eeprom_stage_pkg.sv
package eeprom_stage_pkg;

  // Strobes from the sequencer to the staging datapath
  typedef struct packed {
    logic clearMask;  // forget every loaded byte
    logic loadAddr;   // capture page number and offset
    logic writeByte;  // latch a data byte at the current offset
    logic scanEn;     // commit scan active this clock
  } stageCtrlT;

endpackage

// File: rtl/eeprom_stage_ctrl.sv
module eeprom_stage_ctrl
  import eeprom_stage_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 40,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrBegin,
  input  logic             addrLoad,
  input  logic             dataValid,
  input  logic             stopSeen,
  input  logic             restartSeen,
  input  logic             wpIn,
  input  logic             anyLoaded,
  output stageCtrlT        ctrl,
  output logic [OFS_W-1:0] scanIdx,
  output logic             busy
);

  logic [CNT_W-1:0] cycleCnt;
  logic             busyQ;
  logic             lastCycle;
  logic             startCycle;

  assign lastCycle  = busyQ && (cycleCnt == CNT_W'(WRITE_CYCLES - 1));
  assign startCycle = !busyQ && stopSeen && anyLoaded && !wpIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cycleCnt <= '0;
    end else if (startCycle) begin
      busyQ    <= 1'b1;
      cycleCnt <= '0;
    end else if (lastCycle) begin
      busyQ    <= 1'b0;
      cycleCnt <= '0;
    end else if (busyQ) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.clearMask = lastCycle ||
                     (!busyQ && (wrBegin || restartSeen || (stopSeen && !startCycle)));
    ctrl.loadAddr  = !busyQ && addrLoad;
    ctrl.writeByte = !busyQ && dataValid;
    ctrl.scanEn    = busyQ && (cycleCnt < CNT_W'(PAGE_BYTES));
  end

  assign scanIdx = cycleCnt[OFS_W-1:0];
  assign busy    = busyQ;

endmodule

// File: rtl/eeprom_stage_dpath.sv
module eeprom_stage_dpath
  import eeprom_stage_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtrlT         ctrl,
  input  logic [OFS_W-1:0]  scanIdx,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              anyLoaded,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loadedMask;
  logic [OFS_W-1:0]      offsetPtr;
  logic [PAGE_W-1:0]     pageNum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedMask <= '0;
      offsetPtr  <= '0;
      pageNum    <= '0;
    end else begin
      if (ctrl.clearMask) loadedMask <= '0;
      if (ctrl.loadAddr) begin
        pageNum   <= addrIn[ADDR_W-1:OFS_W];
        offsetPtr <= addrIn[OFS_W-1:0];
      end
      if (ctrl.writeByte) begin
        loadedMask[offsetPtr] <= 1'b1;
        offsetPtr             <= offsetPtr + 1'b1;  // wraps inside the page
      end
    end
  end

  // One latch per page slot
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (ctrl.writeByte && (offsetPtr == OFS_W'(g))) pageBuf[g] <= dataIn;
    end
  end

  assign anyLoaded = |loadedMask;
  assign memWe     = ctrl.scanEn && loadedMask[scanIdx];
  assign memAddr   = {pageNum, scanIdx};
  assign memData   = pageBuf[scanIdx];

endmodule

// File: rtl/eeprom_page_stager.sv
module eeprom_page_stager
  import eeprom_stage_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrBegin,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              stopSeen,
  input  logic              restartSeen,
  input  logic              wpIn,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam int OFS_W = $clog2(PAGE_BYTES);

  stageCtrlT        ctrl;
  logic [OFS_W-1:0] scanIdx;
  logic             anyLoaded;

  eeprom_stage_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrBegin(wrBegin), .addrLoad(addrLoad),
    .dataValid(dataValid), .stopSeen(stopSeen), .restartSeen(restartSeen),
    .wpIn(wpIn), .anyLoaded(anyLoaded), .ctrl(ctrl), .scanIdx(scanIdx),
    .busy(busy)
  );

  eeprom_stage_dpath #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .scanIdx(scanIdx),
    .addrIn(addrIn), .dataIn(dataIn), .anyLoaded(anyLoaded),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

endmodule

// File: rtl/eeprom_stage_chk.sv
module eeprom_stage_chk #(
  parameter int ADDR_W       = 10,
  parameter int OFS_W        = 4,
  parameter int WRITE_CYCLES = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopSeen,
  input logic              restartSeen,
  input logic              wpIn,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= '0;
  end

  // R6: the array is only written inside a write cycle
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R4: a cycle begins only after a stop with protection off
  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(stopSeen) && !$past(wpIn)));

  // R7: a protected stop never starts a cycle
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopSeen && wpIn) |=> !busy);

  // R9: a repeated start never starts a cycle
  p_restart_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && restartSeen && !stopSeen) |=> !busy);

  // R10: the committed page is fixed for the whole cycle
  p_page_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr[ADDR_W-1:OFS_W]));

  // R5: busy never runs longer than the cycle length
  p_busy_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 32'(WRITE_CYCLES));

  // R5: busy never drops before the cycle length
  p_busy_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((busyRun != 0) && (busyRun < 32'(WRITE_CYCLES))) |-> busy);

endmodule

bind eeprom_page_stager eeprom_stage_chk #(
  .ADDR_W(ADDR_W), .OFS_W($clog2(PAGE_BYTES)), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .stopSeen(stopSeen), .restartSeen(restartSeen),
  .wpIn(wpIn), .busy(busy), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/sim_eeprom_page_stager.sv
`timescale 1ns/1ps
module sim_eeprom_page_stager;

  localparam int AW = 10;
  localparam int WC = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrBegin = 0, addrLoad = 0, dataValid = 0, stopSeen = 0, restartSeen = 0, wpIn = 0;
  logic [AW-1:0] addrIn = '0;
  logic [7:0]    dataIn = '0;
  logic          busy, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;

  int errors = 0;
  int checks = 0;
  int weCount = 0;
  logic [7:0] simArr [DEPTH];
  logic [7:0] expArr [DEPTH];

  always #5 clk = ~clk;

  eeprom_page_stager #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rstN(rstN), .wrBegin(wrBegin), .addrLoad(addrLoad), .addrIn(addrIn),
    .dataValid(dataValid), .dataIn(dataIn), .stopSeen(stopSeen),
    .restartSeen(restartSeen), .wpIn(wpIn), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );

  // array model fed by the write port
  always @(posedge clk) begin
    if (memWe) begin
      simArr[memAddr] <= memData;
      weCount <= weCount + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmpRange(input int lo, input int hi, input string tag);
    int bad = -1;
    for (int i = lo; i <= hi; i++) if (bad < 0 && simArr[i] !== expArr[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " array mismatch"}, int'(simArr[bad]), int'(expArr[bad]));
  endtask

  task automatic sendBegin();
    @(negedge clk) wrBegin = 1;
    @(negedge clk) wrBegin = 0;
  endtask
  task automatic sendAddr(input logic [AW-1:0] a);
    @(negedge clk) begin addrLoad = 1; addrIn = a; end
    @(negedge clk) addrLoad = 0;
  endtask
  task automatic sendData(input logic [7:0] d);
    @(negedge clk) begin dataValid = 1; dataIn = d; end
    @(negedge clk) dataValid = 0;
  endtask
  task automatic sendStop();
    @(negedge clk) stopSeen = 1;
    @(negedge clk) stopSeen = 0;
  endtask
  task automatic sendRestart();
    @(negedge clk) restartSeen = 1;
    @(negedge clk) restartSeen = 0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy === 1'b1 && n < 4 * WC) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_byte();
    int n, w0;
    w0 = weCount;
    sendBegin(); sendAddr(10'h123); sendData(8'hA5);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && weCount == w0, "R4 no commit before stop", weCount - w0, 0);
    sendStop();
    chk(busy == 1'b1, "R4 busy after stop", busy, 1);
    waitIdle(n);
    chk(n == WC, "R5 busy length", n, WC);
    expArr[10'h123] = 8'hA5;
    cmpRange(10'h120, 10'h12F, "R2 single byte placement");
  endtask

  task automatic t_seq();
    int n, w0;
    w0 = weCount;
    sendBegin(); sendAddr(10'h205);
    sendData(8'h11); sendData(8'h22); sendData(8'h33);
    sendStop(); waitIdle(n);
    chk(weCount - w0 == 3, "R6 writes only loaded offsets", weCount - w0, 3);
    expArr[10'h205] = 8'h11; expArr[10'h206] = 8'h22; expArr[10'h207] = 8'h33;
    cmpRange(10'h200, 10'h20F, "R2 offset increments, R6 neighbours kept");
  endtask

  task automatic t_wrap();
    int n, w0;
    w0 = weCount;
    sendBegin(); sendAddr(10'h0FA);
    for (int i = 0; i < 20; i++) begin
      sendData(8'(8'h80 + i));
      expArr[10'h0F0 + ((10 + i) % 16)] = 8'(8'h80 + i);
    end
    sendStop(); waitIdle(n);
    chk(weCount - w0 == 16, "R3 full page written once", weCount - w0, 16);
    cmpRange(10'h0F0, 10'h10F, "R3 wrap and overwrite in page");
  endtask

  task automatic t_nodata();
    int w0;
    w0 = weCount;
    sendBegin(); sendAddr(10'h240); sendStop();
    chk(busy == 1'b0, "R8 address-only stop stays idle", busy, 0);
    sendBegin(); sendStop();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && weCount == w0, "R8 control-only stop writes nothing", weCount - w0, 0);
  endtask

  task automatic t_wp();
    int w0;
    w0 = weCount;
    wpIn = 1;
    sendBegin(); sendAddr(10'h300); sendData(8'hC1); sendData(8'hC2); sendStop();
    chk(busy == 1'b0, "R7 protected stop stays idle", busy, 0);
    wpIn = 0;
    sendStop();
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && weCount == w0, "R7 protected bytes discarded", weCount - w0, 0);
    cmpRange(10'h300, 10'h30F, "R7 array unchanged");
  endtask

  task automatic t_restart();
    int w0;
    w0 = weCount;
    sendBegin(); sendAddr(10'h310); sendData(8'h5A); sendRestart(); sendStop();
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && weCount == w0, "R9 restart discards buffer", weCount - w0, 0);
  endtask

  task automatic t_busy_ignore();
    int w0;
    w0 = weCount;
    sendBegin(); sendAddr(10'h320); sendData(8'h44); sendStop();
    // now in busy clock 0
    for (int i = 1; i < WC; i++) begin
      @(negedge clk);
      if (i == 3) begin addrLoad = 1; addrIn = 10'h3A0; dataValid = 1; dataIn = 8'h99; end
      if (i == 4) begin addrLoad = 0; dataValid = 0; end
      if (i == WC - 1) begin dataValid = 1; dataIn = 8'hEE; end
    end
    @(negedge clk) dataValid = 0;
    chk(busy == 1'b0, "R5 busy ends after cycle", busy, 0);
    sendStop();
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && weCount - w0 == 1, "R10 bytes during busy ignored", weCount - w0, 1);
    expArr[10'h320] = 8'h44;
    cmpRange(10'h320, 10'h32F, "R10 commit page kept");
    cmpRange(10'h3A0, 10'h3AF, "R10 address during busy ignored");
  endtask

  task automatic t_clear();
    int n, w0;
    w0 = weCount;
    sendAddr(10'h3C0); sendBegin(); sendData(8'h01); sendData(8'h02);
    sendBegin(); sendAddr(10'h3C8); sendData(8'h77); sendStop(); waitIdle(n);
    chk(weCount - w0 == 1, "R11 begin clears mask", weCount - w0, 1);
    w0 = weCount;
    sendBegin(); sendAddr(10'h3C2); sendData(8'h66); sendStop(); waitIdle(n);
    chk(weCount - w0 == 1, "R11 cycle end clears mask", weCount - w0, 1);
    expArr[10'h3C8] = 8'h77; expArr[10'h3C2] = 8'h66;
    cmpRange(10'h3C0, 10'h3CF, "R11 only own bytes committed");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      simArr[i] = 8'(i) ^ 8'h5C;
      expArr[i] = 8'(i) ^ 8'h5C;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && memWe == 1'b0, "R1 reset state", {busy, memWe}, 0);
    rstN = 1;
    @(negedge clk);
    chk(busy == 1'b0 && memWe == 1'b0, "R1 idle after reset", {busy, memWe}, 0);
    t_byte();
    t_seq();
    t_wrap();
    t_nodata();
    t_wp();
    t_restart();
    t_busy_ignore();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule